// File: doc/BRIEF.md
# Variable-Base Digit Splitter and Carry Normalizer

This block moves numbers between a plain Q-bit integer and a length-N sequence of digits whose bit widths differ by position. This is the digit form used when two integers modulo the Mersenne number 2^Q − 1 are multiplied by a weighted transform. N is a power of two, so the transform needs no zero padding. The weighting and the transform itself are handled elsewhere. This block covers only the two integer conversions that sit around them.

In split mode, one input beat carries a Q-bit operand, and the block returns its N digits, least significant first. In normalize mode, N beats carry wide signed digit values, such as raw convolution outputs. The block releases carries one digit per cycle, shifting each carry by that digit's own width. Because 2^Q ≡ 1 modulo 2^Q − 1, a carry out of the top digit wraps back into digit 0. Sweeping continues until no carry remains. Both modes use the same carry engine, since a split is a normalize whose only nonzero input is digit 0. Results leave one digit per cycle over a valid/ready stream, with a last flag on digit N−1.

Top module: `vbase_digit_norm`

## Requirements
- R1: Digit j has width w_j = ceil(Q·(j+1)/N) − ceil(Q·j/N) and weight 2^(ceil(Q·j/N)). For Q = 37 and N = 4 the widths are 10, 9, 9, 9 from digit 0 upward.
- R2: A beat accepted while the block is idle with `mode` = 0 is a split request. Bits [Q−1:0] of `in_word` form the unsigned operand, and the bits above Q−1 are ignored. The output digits recompose the operand exactly; 78314567209 yields 553, 93, 381, 291.
- R3: A first beat with `mode` = 1 starts a normalize request. It and the next N−1 accepted beats are the signed two's-complement digits 0 to N−1. The mode pin is ignored on those later beats, and gaps between beats are allowed.
- R4: After normalization, the output digits weighted per R1 are congruent modulo 2^Q − 1 to the input digits weighted the same way.
- R5: Every output digit j lies in [0, 2^w_j).
- R6: Negative input digits are handled with arithmetic-shift carries; a lone −1 in digit 0 becomes 1022, 511, 511, 511 for Q = 37, N = 4.
- R7: A carry leaving digit N−1 is added into digit 0; 512 in digit 3 alone, with all other digits 0, yields 1, 0, 0, 0.
- R8: Output digits leave least significant first, one per accepted `o_ready` beat. `o_last` is high only with digit N−1. Digit and flag hold steady while `o_ready` is low.
- R9: `in_ready` is low from the acceptance of the final input beat until the final output digit is taken, and high again in the following cycle.
- R10: After reset, `in_ready` is 1 and `o_valid` is 0.
- R11: A result congruent to zero may come out as all digits at their maximum (2^w_j − 1). Input 2^Q − 1 in digit 0 alone gives 1023, 511, 511, 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | First-beat request type: 0 split, 1 normalize |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_word | input | IW | Operand (split) or signed digit (normalize) |
| o_valid | output | 1 | Output digit valid |
| o_ready | input | 1 | Consumer takes the output digit |
| o_digit | output | WMAX | Normalized digit, zero-extended |
| o_last | output | 1 | Marks digit N−1 |

## Verification
On every cycle, the assertions check the following. Each presented digit fits the width of its position, counted from the output handshakes. The last flag lines up with the Nth digit. A stalled digit stays put. The input side stays closed while results are pending. Only the bench scenarios can show the arithmetic: exact split digits, the modular value of normalized results with positive, negative and wrapping carries, and the all-maximum form of zero. The same holds for gapped input beats and the ignored upper operand bits.

// File: rtl/vbase_digit_norm.sv
module vbase_digit_norm #(
  parameter int Q  = 37,
  parameter int N  = 4,
  parameter int IW = 48,
  localparam int WMAX = (Q + N - 1) / N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   in_word,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [WMAX-1:0] o_digit,
  output logic            o_last
);
  localparam int PW = $clog2(N);
  localparam int SW = $clog2(WMAX + 1);

  typedef enum logic [1:0] {S_IN, S_RUN, S_OUT} st_t;

  function automatic int wid(input int j);
    return (Q * (j + 1) + N - 1) / N - (Q * j + N - 1) / N;
  endfunction

  st_t st;
  logic signed [IW-1:0] digs [N];
  logic signed [IW-1:0] carry;
  logic [PW-1:0] ptr, cnt;
  logic swept;
  logic [SW-1:0] wtab [N];

  for (genvar g = 0; g < N; g++) begin : g_w
    assign wtab[g] = SW'(wid(g));
  end

  logic signed [IW:0]   tsum;
  logic signed [IW-1:0] cnext;
  logic [WMAX-1:0]      mask, low;
  logic                 fin;

  assign tsum  = {digs[ptr][IW-1], digs[ptr]} + {carry[IW-1], carry};
  assign cnext = IW'(tsum >>> wtab[ptr]);
  assign mask  = (WMAX'(1) << wtab[ptr]) - WMAX'(1);
  assign low   = tsum[WMAX-1:0] & mask;
  assign fin   = (swept || ptr == PW'(N - 1)) && cnext == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IN;
      ptr   <= '0;
      cnt   <= '0;
      carry <= '0;
      swept <= 1'b0;
      for (int k = 0; k < N; k++) digs[k] <= '0;
    end else begin
      case (st)
        S_IN: if (in_valid) begin
          ptr   <= '0;
          carry <= '0;
          swept <= 1'b0;
          if (cnt == '0 && !mode) begin
            digs[0] <= {{(IW-Q){1'b0}}, in_word[Q-1:0]};
            for (int k = 1; k < N; k++) digs[k] <= '0;
            st <= S_RUN;
          end else begin
            digs[cnt] <= in_word;
            cnt       <= cnt + 1'b1;
            if (cnt == PW'(N - 1)) st <= S_RUN;
          end
        end
        S_RUN: begin
          digs[ptr] <= {{(IW-WMAX){1'b0}}, low};
          carry     <= cnext;
          ptr       <= ptr + 1'b1;
          if (ptr == PW'(N - 1)) swept <= 1'b1;
          if (fin) begin
            st  <= S_OUT;
            ptr <= '0;
          end
        end
        S_OUT: if (o_ready) begin
          ptr <= ptr + 1'b1;
          if (ptr == PW'(N - 1)) st <= S_IN;
        end
        default: st <= S_IN;
      endcase
    end
  end

  assign in_ready = (st == S_IN);
  assign o_valid  = (st == S_OUT);
  assign o_digit  = digs[ptr][WMAX-1:0];
  assign o_last   = o_valid && ptr == PW'(N - 1);
endmodule

// File: rtl/vbase_digit_norm_chk.sv
module vbase_digit_norm_chk #(
  parameter int Q = 37,
  parameter int N = 4,
  localparam int WMAX = (Q + N - 1) / N
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            o_valid,
  input logic            o_ready,
  input logic [WMAX-1:0] o_digit,
  input logic            o_last
);
  localparam int PW = $clog2(N);

  function automatic int wid(input int j);
    return (Q * (j + 1) + N - 1) / N - (Q * j + N - 1) / N;
  endfunction

  logic [PW-1:0] out_idx;
  logic [WMAX:0] lim;

  always_ff @(posedge clk) begin
    if (!rst_n) out_idx <= '0;
    else if (o_valid && o_ready) out_idx <= out_idx + 1'b1;
  end

  always_comb begin
    lim = '0;
    for (int j = 0; j < N; j++)
      if (out_idx == PW'(j)) lim = (WMAX+1)'(1) << wid(j);
  end

  AST_DIGIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ({1'b0, o_digit} < lim));  // R5
  AST_LAST_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_last == (out_idx == PW'(N - 1))));  // R8
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_digit) && $stable(o_last)));  // R8
  AST_CLOSED_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !in_ready);  // R9
endmodule

bind vbase_digit_norm vbase_digit_norm_chk #(.Q(Q), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .o_valid(o_valid),
  .o_ready(o_ready), .o_digit(o_digit), .o_last(o_last)
);

// File: tb/sim_vbase_digit_norm.sv
module sim_vbase_digit_norm;
  localparam int CLK_P = 10;
  localparam int Q = 37;
  localparam int N = 4;
  localparam int IW = 48;
  localparam int WM = (Q + N - 1) / N;
  localparam longint M = (64'sd1 <<< Q) - 1;

  logic clk = 0, rst_n = 0, mode = 0, in_valid = 0, o_ready = 0;
  logic [IW-1:0] in_word = '0;
  logic in_ready, o_valid, o_last;
  logic [WM-1:0] o_digit;

  int ntot = 0, nfail = 0, cyc = 0;
  longint xin [N];
  longint got [N];

  always #(CLK_P/2) clk = ~clk;

  vbase_digit_norm #(.Q(Q), .N(N), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .o_valid(o_valid), .o_ready(o_ready), .o_digit(o_digit), .o_last(o_last)
  );

  function automatic int offs(input int j);
    return (Q * j + N - 1) / N;
  endfunction
  function automatic int wdt(input int j);
    return offs(j + 1) - offs(j);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      ntot++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  task automatic send(input logic md, input logic [IW-1:0] w);
    @(negedge clk);
    mode = md; in_word = w; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_norm(input bit gap);
    for (int j = 0; j < N; j++) begin
      send((j == 0) ? 1'b1 : 1'b0, xin[j][IW-1:0]);
      if (gap) begin
        @(negedge clk); @(negedge clk);
      end
    end
  endtask

  task automatic collect(input bit stall);
    for (int j = 0; j < N; j++) begin
      logic [WM-1:0] hd;
      logic hl;
      while (!o_valid) @(negedge clk);
      chk(in_ready == 1'b0, "R9 busy", in_ready, 0);
      if (stall) begin
        o_ready = 0;
        hd = o_digit; hl = o_last;
        @(negedge clk); @(negedge clk);
        chk(o_valid && o_digit == hd && o_last == hl, "R8 hold", o_digit, hd);
      end
      got[j] = o_digit;
      chk(o_last == (j == N - 1), "R8 last", o_last, (j == N - 1));
      o_ready = 1;
      @(negedge clk);
      o_ready = 0;
    end
    chk(in_ready == 1'b1 && o_valid == 1'b0, "R9 reopen", in_ready, 1);
  endtask

  function automatic longint value_got();
    longint v = 0;
    for (int j = 0; j < N; j++) v += got[j] <<< offs(j);
    return v;
  endfunction

  task automatic expect_exact(input string req, input longint e0, input longint e1,
                              input longint e2, input longint e3);
    longint e [N];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    for (int j = 0; j < N; j++) chk(got[j] == e[j], req, got[j], e[j]);
  endtask

  task automatic expect_mod(input string req);
    longint v = 0, em, vo;
    for (int j = 0; j < N; j++) v += xin[j] * (64'sd1 <<< offs(j));
    em = ((v % M) + M) % M;
    vo = value_got() % M;
    chk(vo == em, req, vo, em);
    for (int j = 0; j < N; j++)
      chk(got[j] >= 0 && got[j] < (64'sd1 <<< wdt(j)), "R5 range", got[j], wdt(j));
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    chk(o_valid == 1'b0, "R10 o_valid", o_valid, 0);
  endtask

  task automatic t_split_example();
    send(1'b0, IW'(64'd78314567209));
    collect(1'b0);
    expect_exact("R2 split example", 553, 93, 381, 291);
  endtask

  task automatic t_split_widths();
    send(1'b0, {11'h5A5, {Q{1'b1}}});
    collect(1'b0);
    for (int j = 0; j < N; j++)
      chk(got[j] == (64'sd1 <<< wdt(j)) - 1, "R1 width / R2 upper bits ignored",
          got[j], (64'sd1 <<< wdt(j)) - 1);
  endtask

  task automatic t_split_value();
    send(1'b0, {11'h7FF, 37'h12_3456_789A});
    collect(1'b1);
    chk(value_got() == 64'h12_3456_789A, "R2 recompose", value_got(), 64'h12_3456_789A);
  endtask

  task automatic t_norm_pos();
    xin[0] = 1000000; xin[1] = 2000; xin[2] = 123456789; xin[3] = 99999;
    send_norm(1'b1);
    collect(1'b0);
    expect_mod("R3 R4 positive");
  endtask

  task automatic t_norm_neg();
    xin[0] = -5; xin[1] = 300; xin[2] = -1000000; xin[3] = 77;
    send_norm(1'b0);
    collect(1'b1);
    expect_mod("R4 R6 negative");
    xin[0] = -1; xin[1] = 0; xin[2] = 0; xin[3] = 0;
    send_norm(1'b0);
    collect(1'b0);
    expect_exact("R6 minus one", 1022, 511, 511, 511);
  endtask

  task automatic t_wrap();
    xin[0] = 0; xin[1] = 0; xin[2] = 0; xin[3] = 512;
    send_norm(1'b0);
    collect(1'b0);
    expect_exact("R7 wrap", 1, 0, 0, 0);
    xin[0] = 7; xin[1] = -3; xin[2] = 40000; xin[3] = 900000;
    send_norm(1'b1);
    collect(1'b0);
    expect_mod("R7 R4 wrap mixed");
  endtask

  task automatic t_zero_form();
    xin[0] = M; xin[1] = 0; xin[2] = 0; xin[3] = 0;
    send_norm(1'b0);
    collect(1'b0);
    expect_exact("R11 zero as all max", 1023, 511, 511, 511);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_split_example();
    t_split_widths();
    t_split_value();
    t_norm_pos();
    t_norm_neg();
    t_wrap();
    t_zero_form();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule